// File: doc/BRIEF.md
# Bfloat16 Multiplier

This block takes two 16-bit brain-float operands (1 sign bit, 8 exponent bits with bias 127, 7 fraction bits) and produces their product in the same format. A caller presents both operands with a one-cycle `in_vld` strobe. The product appears on `prod` with `out_vld` after a fixed number of register stages, set by the `LATENCY` parameter. The block accepts a new operand pair on every cycle.

Special encodings are decoded first. An exponent field of all ones with a zero fraction is infinity. An exponent field of all ones with a nonzero fraction is NaN. An all-zero exponent and fraction is zero. Subnormal operands are normalised before the multiply: the fraction moves up until its top bit is set, and every shift lowers the result exponent by one. The 8x8 significand product is normalised in one step. Bits below the kept seven are dropped, so there is no rounding. A result that is too large saturates to infinity. A result slightly too small is shifted into the subnormal range over a limited window. Anything smaller becomes zero.

Top module: `bf16_mul_unit`

## Requirements
- R1: For every finite or infinite result that is not produced by a NaN rule, the product sign bit (bit 15) equals the XOR of the two operand sign bits.
- R2: If operand a is NaN (exponent bits 14:7 all ones and fraction bits 6:0 nonzero), the output is a unchanged. Otherwise, if b is NaN, the output is b unchanged.
- R3: Infinity times zero, in either operand order and with any signs, gives the quiet NaN 0x7FC0.
- R4: Infinity times any nonzero finite value or infinity gives a signed infinity: the sign bit, then exponent 0xFF, then fraction 0.
- R5: If either operand is zero and no NaN or infinity is involved, the output is a signed zero: the sign bit followed by fifteen zero bits.
- R6: A subnormal operand (exponent field 0, nonzero fraction) has its fraction shifted left until bit 7 of the 8-bit significand is set. Its exponent is then taken as 1, less one for each shift.
- R7: For finite nonzero operands, the exponent is ea + eb - 127 plus the subnormal adjustment. If bit 15 of the 16-bit significand product is set, the fraction is product bits 14:8 and the exponent increases by one. Otherwise the fraction is product bits 13:7. Lower bits are truncated.
- R8: A result exponent of 255 or more gives a signed infinity.
- R9: A result exponent E in the range -6..0 gives exponent field 0, with the kept 7-bit fraction shifted right by 1 - E.
- R10: A result exponent below -6 gives a signed zero.
- R11: `out_vld` is low after reset. It is high exactly `LATENCY` cycles after each cycle in which `in_vld` is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operand pair valid |
| op_a | input | 16 | First operand, bfloat16 |
| op_b | input | 16 | Second operand, bfloat16 |
| out_vld | output | 1 | Product valid |
| prod | output | 16 | Product, bfloat16 |

## Verification
The bench sweeps every pairing of a grid of operands against an arithmetic model. The grid covers both signs, exponent fields 0, 1, 2, 126..128, 253..255 and boundary fractions, and a long pseudo-random run follows it. Directed cases target the following errors:
- A wrong NaN priority shows up as the wrong payload when both inputs are NaN.
- An infinity-times-zero path that yields infinity instead of 0x7FC0.
- A missing shift count on subnormal inputs gives an exponent that is too large by up to seven.
- Using the wrong product slice gives a fraction that is off by a factor of two.
- An off-by-one in the overflow or underflow thresholds shows up at exponents 255, 0, -6 and -7, where the output would saturate, denormalise or flush on the wrong side.

// File: rtl/bf16m_pkg.sv
package bf16m_pkg;
   localparam int EXP_W   = 8;
   localparam int FRAC_W  = 7;
   localparam int WORD_W  = 1 + EXP_W + FRAC_W;
   localparam int SIG_W   = FRAC_W + 1;
   localparam int PROD_W  = 2 * SIG_W;
   localparam int EXP_MAX = (1 << EXP_W) - 1;
   localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
   localparam int ESUM_W  = EXP_W + 3;
   localparam int SHAMT_W = $clog2(SIG_W);

   typedef enum logic [1:0] {
      K_ZERO = 2'd0,
      K_FIN  = 2'd1,
      K_INF  = 2'd2,
      K_NAN  = 2'd3
   } kind_e;

   typedef struct packed {
      logic                 sign;
      kind_e                kind;
      logic [EXP_W-1:0]     exp;
      logic [SIG_W-1:0]     sig;
      logic [SHAMT_W-1:0]   lead;
   } opnd_t;

   localparam logic [WORD_W-1:0] QNAN_WORD =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
endpackage

// File: rtl/bf16m_unpack.sv
module bf16m_unpack
   import bf16m_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   output opnd_t             opnd
);
   logic [EXP_W-1:0]   e_fld;
   logic [FRAC_W-1:0]  f_fld;
   logic [SHAMT_W-1:0] shift_up;

   assign e_fld = word[WORD_W-2 -: EXP_W];
   assign f_fld = word[FRAC_W-1:0];

   // highest set fraction bit wins: the loop runs upward and overwrites
   always_comb begin
      shift_up = '0;
      for (int i = 0; i < FRAC_W; i++) begin
         if (f_fld[i]) shift_up = SHAMT_W'(FRAC_W - i);
      end
   end

   always_comb begin
      opnd.sign = word[WORD_W-1];
      if (e_fld == EXP_W'(EXP_MAX))
         opnd.kind = (f_fld != '0) ? K_NAN : K_INF;
      else if (e_fld == '0 && f_fld == '0)
         opnd.kind = K_ZERO;
      else
         opnd.kind = K_FIN;

      if (e_fld == '0) begin
         opnd.exp  = EXP_W'(1);
         opnd.sig  = SIG_W'({1'b0, f_fld}) << shift_up;
         opnd.lead = shift_up;
      end else begin
         opnd.exp  = e_fld;
         opnd.sig  = {1'b1, f_fld};
         opnd.lead = '0;
      end
   end
endmodule

// File: rtl/bf16m_core.sv
module bf16m_core
   import bf16m_pkg::*;
#(
   parameter int DENORM_DEPTH = 6
) (
   input  opnd_t             a,
   input  opnd_t             b,
   input  logic [WORD_W-1:0] raw_a,
   input  logic [WORD_W-1:0] raw_b,
   output logic [WORD_W-1:0] res
);
   localparam logic signed [ESUM_W-1:0] E_TOP   = ESUM_W'(EXP_MAX);
   localparam logic signed [ESUM_W-1:0] E_FLOOR = ESUM_W'(-DENORM_DEPTH);
   localparam logic signed [ESUM_W-1:0] E_ONE   = ESUM_W'(1);

   logic                      r_sign;
   logic [PROD_W-1:0]         sprod;
   logic                      hi;
   logic signed [ESUM_W-1:0]  esum;
   logic signed [ESUM_W-1:0]  enorm;
   logic signed [ESUM_W-1:0]  rdist;
   logic [3:0]                rsh;
   logic [FRAC_W-1:0]         fkeep;
   logic [FRAC_W-1:0]         fden;
   logic [WORD_W-1:0]         inf_w;
   logic [WORD_W-1:0]         zero_w;

   assign r_sign = a.sign ^ b.sign;
   assign sprod  = PROD_W'(a.sig) * PROD_W'(b.sig);
   assign hi     = sprod[PROD_W-1];

   assign esum  = ESUM_W'(a.exp) + ESUM_W'(b.exp) - ESUM_W'(BIAS)
                - ESUM_W'(a.lead) - ESUM_W'(b.lead);
   assign enorm = esum + $signed({{(ESUM_W-1){1'b0}}, hi});
   assign fkeep = hi ? sprod[PROD_W-2 -: FRAC_W] : sprod[PROD_W-3 -: FRAC_W];

   assign rdist = E_ONE - enorm;
   assign rsh   = rdist[3:0];
   assign fden  = fkeep >> rsh;

   assign inf_w  = {r_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
   assign zero_w = {r_sign, {(WORD_W-1){1'b0}}};

   always_comb begin
      if (a.kind == K_NAN)
         res = raw_a;
      else if (b.kind == K_NAN)
         res = raw_b;
      else if ((a.kind == K_INF && b.kind == K_ZERO) ||
               (b.kind == K_INF && a.kind == K_ZERO))
         res = QNAN_WORD;
      else if (a.kind == K_INF || b.kind == K_INF)
         res = inf_w;
      else if (a.kind == K_ZERO || b.kind == K_ZERO)
         res = zero_w;
      else if (enorm >= E_TOP)
         res = inf_w;
      else if (enorm > 0)
         res = {r_sign, enorm[EXP_W-1:0], fkeep};
      else if (enorm >= E_FLOOR)
         res = {r_sign, {EXP_W{1'b0}}, fden};
      else
         res = zero_w;
   end
endmodule

// File: rtl/bf16m_stage.sv
module bf16m_stage #(
   parameter int W     = 16,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         d_vld,
   input  logic [W-1:0] d_dat,
   output logic         q_vld,
   output logic [W-1:0] q_dat
);
   generate
      if (DEPTH == 0) begin : g_comb
         assign q_vld = d_vld;
         assign q_dat = d_dat;
      end else begin : g_regs
         logic         v_r [DEPTH];
         logic [W-1:0] d_r [DEPTH];
         for (genvar s = 0; s < DEPTH; s++) begin : g_st
            if (s == 0) begin : g_head
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) begin
                     v_r[0] <= 1'b0;
                     d_r[0] <= '0;
                  end else begin
                     v_r[0] <= d_vld;
                     d_r[0] <= d_dat;
                  end
               end
            end else begin : g_body
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) begin
                     v_r[s] <= 1'b0;
                     d_r[s] <= '0;
                  end else begin
                     v_r[s] <= v_r[s-1];
                     d_r[s] <= d_r[s-1];
                  end
               end
            end
         end
         assign q_vld = v_r[DEPTH-1];
         assign q_dat = d_r[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/bf16_mul_unit.sv
module bf16_mul_unit
   import bf16m_pkg::*;
#(
   parameter int LATENCY      = 2,
   parameter int DENORM_DEPTH = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   output logic              out_vld,
   output logic [WORD_W-1:0] prod
);
   generate
      if (LATENCY < 0 || LATENCY > 8) begin : g_bad_latency
         $error("bf16_mul_unit: LATENCY must lie in 0..8");
      end
      if (DENORM_DEPTH < 0 || DENORM_DEPTH > FRAC_W - 1) begin : g_bad_depth
         $error("bf16_mul_unit: DENORM_DEPTH must lie in 0..FRAC_W-1");
      end
   endgenerate

   opnd_t             ua;
   opnd_t             ub;
   logic [WORD_W-1:0] raw_res;

   bf16m_unpack unpack_a_i (.word(op_a), .opnd(ua));
   bf16m_unpack unpack_b_i (.word(op_b), .opnd(ub));

   bf16m_core #(.DENORM_DEPTH(DENORM_DEPTH)) core_i (
      .a     (ua),
      .b     (ub),
      .raw_a (op_a),
      .raw_b (op_b),
      .res   (raw_res)
   );

   bf16m_stage #(.W(WORD_W), .DEPTH(LATENCY)) stage_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_vld (in_vld),
      .d_dat (raw_res),
      .q_vld (out_vld),
      .q_dat (prod)
   );
endmodule

// File: rtl/bf16_mul_unit_chk.sv
module bf16_mul_unit_chk #(
   parameter int LATENCY = 2
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_vld,
   input logic [15:0] op_a,
   input logic [15:0] op_b,
   input logic        out_vld,
   input logic [15:0] prod
);
   logic        tv;
   logic [15:0] ta;
   logic [15:0] tb;

   generate
      if (LATENCY == 0) begin : g_tap0
         assign tv = in_vld;
         assign ta = op_a;
         assign tb = op_b;
      end else begin : g_tapn
         logic        sv [LATENCY];
         logic [15:0] sa [LATENCY];
         logic [15:0] sb [LATENCY];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < LATENCY; k++) begin
                  sv[k] <= 1'b0;
                  sa[k] <= '0;
                  sb[k] <= '0;
               end
            end else begin
               sv[0] <= in_vld;
               sa[0] <= op_a;
               sb[0] <= op_b;
               for (int k = 1; k < LATENCY; k++) begin
                  sv[k] <= sv[k-1];
                  sa[k] <= sa[k-1];
                  sb[k] <= sb[k-1];
               end
            end
         end
         assign tv = sv[LATENCY-1];
         assign ta = sa[LATENCY-1];
         assign tb = sb[LATENCY-1];
      end
   endgenerate

   logic a_nan, b_nan, a_inf, b_inf, a_zer, b_zer, any_nan, inf_zer;
   assign a_nan   = (ta[14:7] == 8'hFF) && (ta[6:0] != 0);
   assign b_nan   = (tb[14:7] == 8'hFF) && (tb[6:0] != 0);
   assign a_inf   = (ta[14:0] == 15'h7F80);
   assign b_inf   = (tb[14:0] == 15'h7F80);
   assign a_zer   = (ta[14:0] == 15'h0);
   assign b_zer   = (tb[14:0] == 15'h0);
   assign any_nan = a_nan || b_nan;
   assign inf_zer = (a_inf && b_zer) || (b_inf && a_zer);

   // R11
   vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld == tv);

   // R2
   a_nan_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && a_nan) |-> (prod == ta));

   // R3
   inf_zero_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !any_nan && inf_zer) |-> (prod == 16'h7FC0));

   // R5
   signed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !any_nan && !a_inf && !b_inf && (a_zer || b_zer))
         |-> (prod == {ta[15] ^ tb[15], 15'h0}));

   // R1
   sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !any_nan && !inf_zer) |-> (prod[15] == (ta[15] ^ tb[15])));

   // R8
   no_made_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !any_nan && !inf_zer)
         |-> !((prod[14:7] == 8'hFF) && (prod[6:0] != 0)));
endmodule

bind bf16_mul_unit bf16_mul_unit_chk #(.LATENCY(LATENCY)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .in_vld  (in_vld),
   .op_a    (op_a),
   .op_b    (op_b),
   .out_vld (out_vld),
   .prod    (prod)
);

// File: tb/bf16_mul_unit_tb_top.sv
module bf16_mul_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [15:0] op_a = '0;
   logic [15:0] op_b = '0;
   logic        out_vld;
   logic [15:0] prod;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bf16_mul_unit #(.LATENCY(LAT), .DENORM_DEPTH(6)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
      .out_vld(out_vld), .prod(prod)
   );

   function automatic logic [15:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
      int s, ea, eb, ma, mb, adj, e, p, f;
      s  = a[15] ^ b[15];
      ea = a[14:7]; eb = b[14:7]; ma = a[6:0]; mb = b[6:0];
      if (ea == 255 && ma != 0) return a;
      if (eb == 255 && mb != 0) return b;
      if ((ea == 255 && eb == 0 && mb == 0) || (eb == 255 && ea == 0 && ma == 0))
         return 16'h7FC0;
      if (ea == 255 || eb == 255) return 16'(s * 32768 + 16'h7F80);
      if ((ea == 0 && ma == 0) || (eb == 0 && mb == 0)) return 16'(s * 32768);
      adj = 0;
      if (ea == 0) begin
         while (ma < 128) begin ma = ma * 2; adj = adj - 1; end
         ea = 1;
      end else ma = ma + 128;
      if (eb == 0) begin
         while (mb < 128) begin mb = mb * 2; adj = adj - 1; end
         eb = 1;
      end else mb = mb + 128;
      e = ea + eb - 127 + adj;
      p = ma * mb;
      if (p >= 32768) begin f = (p / 256) % 128; e = e + 1; end
      else f = (p / 128) % 128;
      if (e >= 255) return 16'(s * 32768 + 16'h7F80);
      if (e <= 0) begin
         if (e < -6) return 16'(s * 32768);
         f = f >> (1 - e);
         e = 0;
      end
      return 16'(s * 32768 + e * 128 + f);
   endfunction

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // one transaction: drive, wait LAT edges, compare, then confirm valid drops
   task automatic run_op(input string req, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] exp);
      @(negedge clk);
      op_a = a; op_b = b; in_vld = 1'b1;
      @(posedge clk); #1;
      in_vld = 1'b0;
      repeat (LAT - 1) @(posedge clk);
      #1;
      check({req, " R11 valid"}, {15'h0, out_vld}, 16'h1);
      check(req, prod, exp);
      @(posedge clk); #1;
      check("R11 valid drop", {15'h0, out_vld}, 16'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] grid [120];
      logic [15:0] lfsr;
      int          gi;
      int          exps [12];
      int          mans [5];
      exps = '{0, 1, 2, 60, 100, 126, 127, 128, 200, 253, 254, 255};
      mans = '{0, 1, 8'h40, 8'h55, 8'h7F};

      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      check("R11 reset valid", {15'h0, out_vld}, 16'h0);
      check("R11 reset data", prod, 16'h0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R11 idle valid", {15'h0, out_vld}, 16'h0);

      // directed corners
      run_op("R7 1.0*2.0",           16'h3F80, 16'h4000, 16'h4000);
      run_op("R7 1.5*2.0",           16'h3FC0, 16'h4000, 16'h4040);
      run_op("R7 bit15 product",     16'h3FFF, 16'h3FFF, 16'h407E);
      run_op("R1 neg*pos",           16'hBF80, 16'h3F80, 16'hBF80);
      run_op("R1 neg*neg",           16'hBFC0, 16'hC000, 16'h4040);
      run_op("R2 a NaN first",       16'h7FC1, 16'h7F81, 16'h7FC1);
      run_op("R2 b NaN",             16'h3F80, 16'hFF90, 16'hFF90);
      run_op("R2 b NaN with a inf",  16'h7F80, 16'h7F85, 16'h7F85);
      run_op("R3 inf*zero",          16'h7F80, 16'h0000, 16'h7FC0);
      run_op("R3 negzero*neginf",    16'h8000, 16'hFF80, 16'h7FC0);
      run_op("R4 inf*finite",        16'hFF80, 16'h3F80, 16'hFF80);
      run_op("R4 subnormal*inf",     16'h0001, 16'h7F80, 16'h7F80);
      run_op("R5 negzero*one",       16'h8000, 16'h3F80, 16'h8000);
      run_op("R5 subnormal*zero",    16'h0003, 16'h8000, 16'h8000);
      run_op("R6 subnormal input",   16'h0001, 16'h4B00, 16'h0880);
      run_op("R8 overflow",          16'h7F00, 16'h7F00, 16'h7F80);
      run_op("R8 neg overflow",      16'hFF00, 16'h7F00, 16'hFF80);
      run_op("R9 exponent 0",        16'h00C0, 16'h3F00, 16'h0020);
      run_op("R9 exponent -5",       16'h00C0, 16'h3C80, 16'h0001);
      run_op("R9 exponent -6",       16'h80C0, 16'h3C00, 16'h8000);
      run_op("R10 exponent -7",      16'h80C0, 16'h3B80, 16'h8000);

      // grid sweep over signs, exponent corners and fraction corners
      gi = 0;
      for (int s = 0; s < 2; s++)
         for (int ei = 0; ei < 12; ei++)
            for (int mi = 0; mi < 5; mi++) begin
               grid[gi] = 16'(s * 32768 + exps[ei] * 128 + mans[mi]);
               gi++;
            end
      for (int i = 0; i < 120; i++)
         for (int j = 0; j < 120; j++)
            run_op("R7 grid", grid[i], grid[j], ref_mul(grid[i], grid[j]));

      // pseudo-random operand pairs
      lfsr = 16'hACE1;
      for (int k = 0; k < 4000; k++) begin
         logic [15:0] ra;
         logic [15:0] rb;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         ra = lfsr;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rb = lfsr ^ 16'h5A3C;
         run_op("R9 R10 random", ra, rb, ref_mul(ra, rb));
      end

      finish_run();
   end
endmodule